// File: doc/BRIEF.md
# Successive approximation register controller

This block is the digital half of a successive-approximation converter. It holds the sequencer and the result register. It drives a parallel code into an external DAC and reads back one comparator level. The comparator level is high when the analog input is at or above the DAC output.

A low pulse on the asynchronous reset `rst_ni` starts a conversion. During the pulse the sequencer loads a single 1 at the MSB position, and the result register clears. After the pulse ends, the token moves one position toward the LSB on every rising clock edge, and zeros enter behind it.

The bit under the token is presented to the DAC as a trial 1. The edge that moves the token off a bit is also the edge that captures the comparator into that bit. Result bits below the token read 0 until their turn. When the LSB has been resolved, `done_o` rises. The code then holds until the next reset pulse.

Top module: `sar_ctrl`

## Requirements
- R1: While `rst_ni` is low, `dac_o` shows only its MSB set (code 2^(W-1)) and `done_o` is 0.
- R2: After k rising edges following reset release (0 <= k < W), the trial position is p = W-1-k. Bit p of `dac_o` is 1, and all bits below p are 0.
- R3: The edge that moves the token from bit p to bit p-1 captures `cmp_i` into result bit p. A 1 keeps the bit and a 0 clears it. A bit that has been resolved never changes again within the conversion.
- R4: `done_o` is 0 for the first W-1 edges after release. It is 1 after the W-th edge, which resolves bit 0.
- R5: With an ideal comparator (`cmp_i` = input code >= `dac_o`), the final `dac_o` equals the input code.
- R6: Once `done_o` is 1, `dac_o` and `done_o` hold their values whatever `cmp_i` does, until the next reset pulse.
- R7: A reset pulse in the middle of a conversion abandons that conversion and restarts from the R1 state.
- R8: The behaviour holds for any width W >= 2. The default W is 10, and a 4-bit instance behaves the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset, doubling as start of conversion |
| cmp_i | input | 1 | Comparator level: 1 when input >= DAC output |
| dac_o | output | W | Resolved bits, plus the trial bit, driving the DAC |
| done_o | output | 1 | Conversion complete, result valid |

## Verification
The bench targets the extreme codes 0 and all-ones, and a comparator forced to a constant level. It also covers a restart issued partway through a conversion, and comparator toggling after completion.

Each of these corner cases catches a specific fault:
- A design that samples the comparator one edge late, or into the wrong bit, gives a wrong final code.
- A design whose lower bits are not cleared shows stray ones in the intermediate codes.
- A design that asserts done one cycle early or late fails the per-edge trace.
- A design whose result keeps sampling after done changes its code when the comparator toggles later.

Random input codes run on both a 10-bit and a 4-bit instance.

// File: rtl/sar_pkg.sv
package sar_pkg;
  parameter int unsigned SAR_W_DEF = 10;

  function automatic int unsigned msb_idx(input int unsigned w);
    return w - 1;
  endfunction
endpackage

// File: rtl/sar_seq.sv
// One-hot sequencer: loads MSB during reset, shifts toward LSB with zero fill.
module sar_seq #(
  parameter int unsigned W = sar_pkg::SAR_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] token_o
);
  localparam int unsigned Msb = sar_pkg::msb_idx(W);

  logic [W-1:0] token_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      token_q      <= '0;
      token_q[Msb] <= 1'b1;
    end else begin
      token_q <= {1'b0, token_q[W-1:1]};
    end
  end

  assign token_o = token_q;
endmodule

// File: rtl/sar_bit.sv
// One result bit: captures comparator on the edge the token leaves it.
module sar_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tok_i,
  input  logic cmp_i,
  output logic bit_o
);
  logic res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    res_q <= 1'b0;
    else if (tok_i) res_q <= cmp_i;
  end

  // trial value while the token sits here
  assign bit_o = res_q | tok_i;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int unsigned W = sar_pkg::SAR_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmp_i,
  output logic [W-1:0] dac_o,
  output logic         done_o
);
  logic [W-1:0] token_q;
  logic         done_q;

  sar_seq #(.W(W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .token_o(token_q)
  );

  for (genvar n = 0; n < W; n++) begin : g_bit
    sar_bit u_bit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tok_i (token_q[n]),
      .cmp_i (cmp_i),
      .bit_o (dac_o[n])
    );
  end

  // LSB resolved on the edge the token leaves bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         done_q <= 1'b0;
    else if (token_q[0]) done_q <= 1'b1;
  end

  assign done_o = done_q;
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int unsigned W = sar_pkg::SAR_W_DEF
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cmp_i,
  input logic [W-1:0] dac_o,
  input logic         done_o,
  input logic [W-1:0] token_i
);
  a_r2_token_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(token_i));

  a_r2_lower_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (token_i != '0) |-> ((dac_o & (token_i - 1'b1)) == '0));

  a_r3_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((token_i != '0) && cmp_i) |=> ((dac_o & $past(token_i)) == $past(token_i)));

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((token_i != '0) && !cmp_i) |=> ((dac_o & $past(token_i)) == '0));

  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (token_i == '0));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && $stable(dac_o)));
endmodule

bind sar_ctrl sar_ctrl_chk #(.W(W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cmp_i  (cmp_i),
  .dac_o  (dac_o),
  .done_o (done_o),
  .token_i(token_q)
);

// File: tb/sar_ctrl_bench.sv
`timescale 1ns/1ps
module sar_ctrl_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_a = 1'b0, rst_b = 1'b0;
  logic [9:0] vin_a = '0;
  logic [3:0] vin_b = '0;
  logic       frc = 1'b0, fval = 1'b0;
  logic [9:0] dac_a;
  logic [3:0] dac_b;
  logic       done_a, done_b, cmp_a, cmp_b;

  assign cmp_a = frc ? fval : (vin_a >= dac_a);
  assign cmp_b = frc ? fval : (vin_b >= dac_b);

  sar_ctrl u_sar_ctrl (
    .clk_i(clk), .rst_ni(rst_a), .cmp_i(cmp_a), .dac_o(dac_a), .done_o(done_a));

  sar_ctrl #(.W(4)) u_sar_ctrl_w4 (
    .clk_i(clk), .rst_ni(rst_b), .cmp_i(cmp_b), .dac_o(dac_b), .done_o(done_b));

  int total = 0, bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int get_dac(input bit big);
    return big ? int'(dac_a) : int'(dac_b);
  endfunction

  function automatic int get_done(input bit big);
    return big ? int'(done_a) : int'(done_b);
  endfunction

  // expected code after k edges: resolved bits above p, trial at p, zeros below
  function automatic int exp_code(input int n, input int kept, input int k);
    int p = n - 1 - k;
    if (k >= n) return kept;
    return (kept & ~((1 << (p + 1)) - 1)) | (1 << p);
  endfunction

  task automatic set_rst(input bit big, input logic v);
    if (big) rst_a = v;
    else     rst_b = v;
  endtask

  // start a conversion and stop after 'edges' edges (aborted run)
  task automatic partial(input bit big, input int edges);
    @(negedge clk);
    set_rst(big, 1'b0);
    @(negedge clk);
    set_rst(big, 1'b1);
    repeat (edges) @(negedge clk);
  endtask

  task automatic run(input bit big, input int v, input bit f, input bit fv);
    int n = big ? 10 : 4;
    int m = (1 << n) - 1;
    int kept;
    int snap;

    frc  = f;
    fval = fv;
    if (big) vin_a = 10'(v);
    else     vin_b = 4'(v & m);
    kept = f ? (fv ? m : 0) : (v & m);

    @(negedge clk);
    set_rst(big, 1'b0);
    @(negedge clk);
    chk("R1 reset code", get_dac(big), 1 << (n - 1));
    chk("R1 reset done", get_done(big), 0);
    set_rst(big, 1'b1);

    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k < n) begin
        chk("R2/R3 trace", get_dac(big), exp_code(n, kept, k));
        chk("R4 done low", get_done(big), 0);
      end else begin
        chk(big ? "R5 final" : "R8 final w4", get_dac(big), kept);
        chk("R4 done high", get_done(big), 1);
      end
    end

    snap = get_dac(big);
    frc  = 1'b1;
    for (int i = 0; i < 3; i++) begin
      fval = 1'($urandom);
      @(negedge clk);
      chk("R6 hold code", get_dac(big), snap);
      chk("R6 hold done", get_done(big), 1);
    end
    frc = 1'b0;
  endtask

  bit timed_out = 1'b0;

  initial begin
    #(5.0 * 150000);
    timed_out = 1'b1;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (2) @(negedge clk);
    rst_a = 1'b1;
    rst_b = 1'b1;

    // directed corners
    run(1'b1, 0, 1'b0, 1'b0);
    run(1'b1, 1023, 1'b0, 1'b0);
    run(1'b1, 512, 1'b0, 1'b0);
    run(1'b1, 511, 1'b0, 1'b0);
    run(1'b1, 0, 1'b1, 1'b1);   // R3 comparator stuck high keeps every trial
    run(1'b1, 0, 1'b1, 1'b0);   // R3 comparator stuck low clears every trial
    run(1'b0, 0, 1'b0, 1'b0);
    run(1'b0, 15, 1'b0, 1'b0);
    run(1'b0, 6, 1'b0, 1'b0);

    // R7 restart mid conversion
    partial(1'b1, 4);
    run(1'b1, 341, 1'b0, 1'b0);
    partial(1'b0, 2);
    run(1'b0, 9, 1'b0, 1'b0);

    // R5 / R8 random codes
    for (int i = 0; i < 40; i++) run(1'b1, int'($urandom_range(0, 1023)), 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) run(1'b0, int'($urandom_range(0, 15)), 1'b0, 1'b0);

    if (!timed_out) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule